// File: doc/BRIEF.md
# Region-Aware Memory Access Sequencer

This block takes one load or store at a time from a processor core and turns it into the traffic that the addressed memory region needs. Each 64 KiB page of the address space has a configured region type. A page on the shared, handshaked bus gets wide or misaligned requests broken into narrower transfers. Each transfer waits for a bus acknowledge before the next one goes out. A page of directly attached fast memory gets one transfer and a timing charge. That charge is a count of memory-cycle units, and it depends on the width of the memory, the access size and the two low address bits.

A fast access returns its data and pulses `done` at once. The rest of its charge is posted as a debt. The debt counts down in the background, and the block takes no new request until the debt reaches zero. The shared bus also carries the split parts of wide and misaligned requests. Read data always comes back right-aligned, and the sub-transfers are assembled high part first. A small write port loads the page-type table. A page with no type, or a page beyond the table, is served on the fast port with no wait.

Top module: `region_access_seq`

## Requirements
- R1: The page type is `tbl[addr[18:16]]`, written through `cfg_we`/`cfg_page`/`cfg_type`. The codes are 0 none, 1 shared bus, 2 fast 32-bit and 3 fast 16-bit. An address with any bit above bit 18 set has no type, and neither does a page whose code is 0. The table resets to all zero, and a later write changes how the next access to that page is handled.
- R2: On a shared page, a long access (size code 2) with `addr[1:0]` = 0 is one long transfer. Any other long access is two word transfers (size code 1): the first at addr carries bits 31:16, the second at addr+2 carries bits 15:0.
- R3: On a shared page, a word access that is not a fetch, with `addr[1:0]` = 3, becomes two byte transfers (size code 0): the first at addr carries bits 15:8, the second at addr+1 carries bits 7:0. Every other word access is a single word transfer.
- R4: On a shared page, a byte or word instruction fetch (`req_fetch` = 1) is always one transfer at the requested size, whatever its alignment.
- R5: A shared-bus transfer keeps `bus_req`, `bus_addr`, `bus_size` and `bus_wdata` steady until `bus_ack` is seen. The next transfer then starts on the following cycle.
- R6: On a fast 32-bit page, a long access costs 1 unit when aligned and 2 units otherwise.
- R7: On a fast 16-bit page, every long access costs 2 units.
- R8: On either fast page, a word access costs 2 units when `addr[1:0]` = 3 and 1 unit otherwise, and a byte access costs 1 unit.
- R9: A fast access of U units issues `fmem_en` for one cycle and raises `done` on the next cycle. `req_ready` then stays low for U*MEM_CYCLE-1 cycles counted from the `done` cycle, so the owed cycles are retired before a new request is accepted.
- R10: An access with no page type is one fast-port transfer. `done` comes one cycle after the issue, and `req_ready` is high in the `done` cycle.
- R11: `done` is a single-cycle pulse. `rdata` holds the result, right-aligned (a byte in bits 7:0, a word in 15:0), until the next completion.
- R12: A split long write puts `wdata[31:16]` and then `wdata[15:0]` on the bus. These land in memory so that a later long read at the same address returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Page-type table write strobe |
| cfg_page | input | PIDX_W | Page index to write |
| cfg_type | input | 2 | Region type code to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 for a store |
| req_fetch | input | 1 | 1 for an instruction fetch |
| req_wdata | input | 32 | Store data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Load result, right-aligned |
| bus_req | output | 1 | Shared-bus transfer request |
| bus_addr | output | ADDR_W | Shared-bus transfer address |
| bus_size | output | 2 | Shared-bus transfer size code |
| bus_write | output | 1 | Shared-bus write |
| bus_wdata | output | 32 | Shared-bus write data, right-aligned |
| bus_ack | input | 1 | Shared-bus acknowledge, ends the transfer |
| bus_rdata | input | 32 | Shared-bus read data, valid with ack |
| fmem_en | output | 1 | Fast-port access strobe, one cycle |
| fmem_addr | output | ADDR_W | Fast-port address |
| fmem_size | output | 2 | Fast-port size code |
| fmem_write | output | 1 | Fast-port write |
| fmem_wdata | output | 32 | Fast-port write data |
| fmem_rdata | input | 32 | Fast-port read data, same cycle as fmem_en |

## Verification
A wrong unit count or a corrupted debt register is visible one cycle after `done`. It shows up as a `req_ready` low window of the wrong length, which the bench measures for every fast access. A wrong split decision or a wrong sub-transfer pointer shows on the bus within the first transfer, as a wrong address, size or data half at acknowledge. It also comes back as assembled read data with its halves swapped or zeroed at the `done` pulse. A stale page-table entry shows on the first access after reconfiguration, because the wrong port is used and the cost is wrong.

// File: rtl/region_access_seq.sv
module region_access_seq #(
  parameter int ADDR_W    = 32,
  parameter int TBL_PAGES = 8,
  parameter int MEM_CYCLE = 3,
  localparam int PIDX_W   = (TBL_PAGES > 1) ? $clog2(TBL_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_page,
  input  logic [1:0]        cfg_type,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              fmem_en,
  output logic [ADDR_W-1:0] fmem_addr,
  output logic [1:0]        fmem_size,
  output logic              fmem_write,
  output logic [31:0]       fmem_wdata,
  input  logic [31:0]       fmem_rdata
);
  localparam int DW = $clog2(2 * MEM_CYCLE + 1);
  localparam logic [1:0] RT_NONE = 2'd0, RT_SHARED = 2'd1, RT_FAST32 = 2'd2, RT_FAST16 = 2'd3;
  localparam logic [1:0] SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_FAST = 2'd1, ST_BUS = 2'd2;

  logic [1:0]        tbl [TBL_PAGES];
  logic [1:0]        st;
  logic [DW-1:0]     debt;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [1:0]        a_size, b_size, a_cost;
  logic              a_wr, a_fetch;
  logic [31:0]       a_wdata, b_wdata;
  logic              b_last, b_split, b_words;
  logic [15:0]       acc;

  logic [PIDX_W-1:0] pg;
  logic              in_tbl;
  logic [1:0]        rtype, units;
  logic              split;
  logic              accept;

  function automatic logic [31:0] fit(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_B:    fit = {24'd0, d[7:0]};
      SZ_W:    fit = {16'd0, d[15:0]};
      default: fit = d;
    endcase
  endfunction

  assign pg     = req_addr[16 +: PIDX_W];
  assign in_tbl = (req_addr[ADDR_W-1:16+PIDX_W] == '0) && (int'(pg) < TBL_PAGES);
  assign rtype  = in_tbl ? tbl[pg] : RT_NONE;
  assign accept = req_valid && req_ready;
  assign split  = (rtype == RT_SHARED) &&
                  (((req_size == SZ_L) && (req_addr[1:0] != 2'd0)) ||
                   ((req_size == SZ_W) && (req_addr[1:0] == 2'd3) && !req_fetch));

  always_comb begin
    units = 2'd1;
    case (rtype)
      RT_FAST32: if (req_size == SZ_L) units = (req_addr[1:0] != 2'd0) ? 2'd2 : 2'd1;
                 else if (req_size == SZ_W && req_addr[1:0] == 2'd3) units = 2'd2;
      RT_FAST16: if (req_size == SZ_L) units = 2'd2;
                 else if (req_size == SZ_W && req_addr[1:0] == 2'd3) units = 2'd2;
      default:   units = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_PAGES; i++) tbl[i] <= RT_NONE;
    end else if (cfg_we && int'(cfg_page) < TBL_PAGES) begin
      tbl[cfg_page] <= cfg_type;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; debt <= '0; done <= 1'b0; rdata <= '0;
      a_addr <= '0; a_size <= SZ_B; a_cost <= '0; a_wr <= 1'b0; a_fetch <= 1'b0; a_wdata <= '0;
      b_addr <= '0; b_size <= SZ_B; b_wdata <= '0; b_last <= 1'b0; b_split <= 1'b0; b_words <= 1'b0;
      acc <= '0;
    end else begin
      done <= 1'b0;
      if (debt != '0) debt <= debt - 1'b1;
      case (st)
        ST_IDLE: if (accept) begin
          a_addr <= req_addr; a_size <= req_size; a_wr <= req_write;
          a_fetch <= req_fetch; a_wdata <= req_wdata; a_cost <= units;
          if (rtype == RT_SHARED) begin
            st      <= ST_BUS;
            b_addr  <= req_addr;
            b_last  <= !split;
            b_split <= split;
            b_words <= (req_size == SZ_L);
            b_size  <= split ? ((req_size == SZ_L) ? SZ_W : SZ_B) : req_size;
            b_wdata <= !split ? req_wdata :
                       (req_size == SZ_L) ? {16'd0, req_wdata[31:16]} : {24'd0, req_wdata[15:8]};
          end else begin
            st <= ST_FAST;
          end
        end
        ST_FAST: begin
          st    <= ST_IDLE;
          done  <= 1'b1;
          rdata <= fit(fmem_rdata, a_size);
          debt  <= (a_cost == 2'd0) ? '0 : DW'(int'(a_cost) * MEM_CYCLE - 1);
        end
        ST_BUS: if (bus_ack) begin
          if (b_last) begin
            st    <= ST_IDLE;
            done  <= 1'b1;
            rdata <= !b_split ? fit(bus_rdata, b_size) :
                     b_words ? {acc, bus_rdata[15:0]} : {16'd0, acc[7:0], bus_rdata[7:0]};
          end else begin
            acc     <= b_words ? bus_rdata[15:0] : {8'd0, bus_rdata[7:0]};
            b_addr  <= b_addr + (b_words ? ADDR_W'(2) : ADDR_W'(1));
            b_wdata <= b_words ? {16'd0, a_wdata[15:0]} : {24'd0, a_wdata[7:0]};
            b_last  <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE) && (debt == '0);
  assign bus_req    = (st == ST_BUS);
  assign bus_addr   = b_addr;
  assign bus_size   = b_size;
  assign bus_write  = a_wr;
  assign bus_wdata  = b_wdata;
  assign fmem_en    = (st == ST_FAST);
  assign fmem_addr  = a_addr;
  assign fmem_size  = a_size;
  assign fmem_write = a_wr;
  assign fmem_wdata = a_wdata;

  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata));
  a_r2_long_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size == SZ_L |-> bus_addr[1:0] == 2'd0);
  a_r3_no_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size == SZ_W && !a_fetch && a_size == SZ_W |-> bus_addr[1:0] != 2'd3);
  a_r9_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
    fmem_en |=> done && !fmem_en);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && fmem_en));
endmodule

// File: tb/tb_region_access_seq.sv
module tb_region_access_seq;
  localparam int MC = 3;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_page = 0; logic [1:0] cfg_type = 0;
  logic req_valid = 0, req_write = 0, req_fetch = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0] req_size = 0;
  logic req_ready, done, bus_req, bus_write, fmem_en, fmem_write;
  logic [31:0] rdata, bus_addr, bus_wdata, fmem_addr, fmem_wdata;
  logic [1:0] bus_size, fmem_size;
  logic bus_ack = 0; logic [31:0] bus_rdata = 0, fmem_rdata;

  region_access_seq #(.ADDR_W(32), .TBL_PAGES(8), .MEM_CYCLE(MC)) dut (
    .clk, .rst_n, .cfg_we, .cfg_page, .cfg_type, .req_valid, .req_ready, .req_addr,
    .req_size, .req_write, .req_fetch, .req_wdata, .done, .rdata, .bus_req, .bus_addr,
    .bus_size, .bus_write, .bus_wdata, .bus_ack, .bus_rdata, .fmem_en, .fmem_addr,
    .fmem_size, .fmem_write, .fmem_wdata, .fmem_rdata);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [256];
  int ntr = 0, wcnt = 0;
  logic [31:0] tr_addr [4], tr_wd [4];
  logic [1:0]  tr_size [4];

  function automatic logic [31:0] rd_be(input logic [31:0] a, input logic [1:0] sz);
    logic [7:0] i = a[7:0];
    case (sz)
      2'd0: return {24'd0, mem[i]};
      2'd1: return {16'd0, mem[i], mem[8'(i+1)]};
      default: return {mem[i], mem[8'(i+1)], mem[8'(i+2)], mem[8'(i+3)]};
    endcase
  endfunction

  task automatic wr_be(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [7:0] i = a[7:0];
    case (sz)
      2'd0: mem[i] = d[7:0];
      2'd1: begin mem[i] = d[15:8]; mem[8'(i+1)] = d[7:0]; end
      default: begin mem[i] = d[31:24]; mem[8'(i+1)] = d[23:16];
                     mem[8'(i+2)] = d[15:8]; mem[8'(i+3)] = d[7:0]; end
    endcase
  endtask

  assign fmem_rdata = rd_be(fmem_addr, fmem_size);
  always @(posedge clk) if (fmem_en && fmem_write) wr_be(fmem_addr, fmem_size, fmem_wdata);

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 0;
    else if (bus_req) begin
      if (wcnt < 2) wcnt++;
      else begin
        wcnt = 0;
        if (ntr < 4) begin tr_addr[ntr] = bus_addr; tr_size[ntr] = bus_size; tr_wd[ntr] = bus_wdata; end
        ntr++;
        if (bus_write) wr_be(bus_addr, bus_size, bus_wdata);
        else bus_rdata = rd_be(bus_addr, bus_size);
        bus_ack = 1;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic cfg(input int p, input logic [1:0] t);
    @(negedge clk); cfg_we = 1; cfg_page = 3'(p); cfg_type = t;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr, input logic f,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat, output int hold);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ntr = 0;
    req_addr = a; req_size = sz; req_write = wr; req_fetch = f; req_wdata = wd; req_valid = 1;
    @(negedge clk); req_valid = 0; lat = 0;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    rd = rdata; hold = 0;
    while (!req_ready && hold < 1000) begin hold++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R9 reset ready", 32'(req_ready), 1);
    chk("R11 reset done", 32'(done), 0);
    chk("R5 reset bus_req", 32'(bus_req), 0);
    chk("R9 reset fmem_en", 32'(fmem_en), 0);
  endtask

  task automatic t_shared_long;
    logic [31:0] rd, e; int lat, hold;
    e = rd_be(32'h08, 2'd2);
    run(32'h0000_0008, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R2 aligned data", rd, e); chk("R2 aligned count", 32'(ntr), 1);
    chk("R2 aligned size", 32'(tr_size[0]), 2);
    e = rd_be(32'h06, 2'd2);
    run(32'h0000_0006, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R2 split data", rd, e); chk("R2 split count", 32'(ntr), 2);
    chk("R2 first addr", tr_addr[0], 32'h06); chk("R2 second addr", tr_addr[1], 32'h08);
    chk("R2 sub size", 32'(tr_size[1]), 1);
    run(32'h0000_0021, 2'd2, 1, 0, 32'hA1B2_C3D4, rd, lat, hold);
    chk("R12 upper half", tr_wd[0], 32'h0000_A1B2); chk("R12 lower half", tr_wd[1], 32'h0000_C3D4);
    chk("R12 second addr", tr_addr[1], 32'h23);
    run(32'h0001_0021, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R12 readback", rd, 32'hA1B2_C3D4);
  endtask

  task automatic t_shared_word;
    logic [31:0] rd, e; int lat, hold;
    e = rd_be(32'h13, 2'd1);
    run(32'h0000_0013, 2'd1, 0, 0, 0, rd, lat, hold);
    chk("R3 split data", rd, e); chk("R3 split count", 32'(ntr), 2);
    chk("R3 second addr", tr_addr[1], 32'h14); chk("R3 byte size", 32'(tr_size[0]), 0);
    e = rd_be(32'h12, 2'd1);
    run(32'h0000_0012, 2'd1, 0, 0, 0, rd, lat, hold);
    chk("R3 single data", rd, e); chk("R3 single count", 32'(ntr), 1);
    run(32'h0000_0033, 2'd1, 1, 0, 32'h0000_5A6B, rd, lat, hold);
    chk("R3 write high byte", tr_wd[0], 32'h5A); chk("R3 write low byte", tr_wd[1], 32'h6B);
  endtask

  task automatic t_fetch;
    logic [31:0] rd, e; int lat, hold;
    e = rd_be(32'h43, 2'd1);
    run(32'h0000_0043, 2'd1, 0, 1, 0, rd, lat, hold);
    chk("R4 word fetch count", 32'(ntr), 1); chk("R4 word fetch size", 32'(tr_size[0]), 1);
    chk("R4 word fetch data", rd, e);
    e = rd_be(32'h45, 2'd0);
    run(32'h0000_0045, 2'd0, 0, 1, 0, rd, lat, hold);
    chk("R4 byte fetch count", 32'(ntr), 1); chk("R11 byte right-aligned", rd, e);
  endtask

  task automatic t_fast;
    logic [31:0] rd, e; int lat, hold;
    e = rd_be(32'h40, 2'd2);
    run(32'h0001_0040, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R6 aligned data", rd, e); chk("R9 fast latency", 32'(lat), 1);
    chk("R6 aligned hold", 32'(hold), 1*MC-1); chk("R6 no bus use", 32'(ntr), 0);
    chk("R11 done pulse", 32'(done), 0); chk("R11 rdata held", rdata, e);
    run(32'h0001_0042, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R6 misaligned hold", 32'(hold), 2*MC-1);
    run(32'h0002_0040, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R7 aligned hold", 32'(hold), 2*MC-1);
    run(32'h0002_0041, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R7 misaligned hold", 32'(hold), 2*MC-1);
    run(32'h0001_0053, 2'd1, 0, 0, 0, rd, lat, hold);
    chk("R8 word off3 hold", 32'(hold), 2*MC-1);
    run(32'h0002_0051, 2'd1, 0, 0, 0, rd, lat, hold);
    chk("R8 word off1 hold", 32'(hold), 1*MC-1);
    e = rd_be(32'h53, 2'd0);
    run(32'h0002_0053, 2'd0, 0, 0, 0, rd, lat, hold);
    chk("R8 byte hold", 32'(hold), 1*MC-1); chk("R8 byte data", rd, e);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd, e; int lat, hold;
    e = rd_be(32'h10, 2'd2);
    run(32'h0003_0010, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R10 latency", 32'(lat), 1); chk("R10 hold", 32'(hold), 0);
    chk("R10 data", rd, e); chk("R10 no bus", 32'(ntr), 0);
    run(32'h00F0_0010, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R1 beyond table hold", 32'(hold), 0);
    cfg(3, 2'd3);
    run(32'h0003_0010, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R1 reconfigured hold", 32'(hold), 2*MC-1);
    cfg(3, 2'd1);
    run(32'h0003_0012, 2'd2, 0, 0, 0, rd, lat, hold);
    chk("R1 reconfigured to bus", 32'(ntr), 2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    cfg(0, 2'd1); cfg(1, 2'd2); cfg(2, 2'd3);
    t_shared_long();
    t_shared_word();
    t_fetch();
    t_fast();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule